// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Output Coding

This block runs one 12-bit successive-approximation conversion for an analog front end that sits outside it. The front end holds the track/hold, the capacitive DAC, the comparator and the reference. A single-cycle start request opens a conversion. The block first takes a sign sample, with the DAC code at zero and `sign_chk_o` raised. It then makes a binary search of twelve steps. In each step it drives a trial code on `trial_o` and reads one comparator decision on `cmp_i`. A high decision means the input is at or above the trial level.

When the last bit is decided, the block codes the result according to the mode bits captured at start and raises `done_o` for one cycle. Single-ended mode always gives straight binary. Differential unipolar mode gives straight binary, and the code is zero if the sign sample showed a negative input. Differential bipolar mode gives two's complement. The front end is assumed to resolve the input magnitude during a unipolar differential search, so the sign sample is what makes the clamp to zero.

The controller has four states. `ST_IDLE` waits and goes to `ST_SIGN` when start is accepted. `ST_SIGN` always moves on to `ST_CONV` after one cycle. `ST_CONV` stays for twelve cycles, one per bit, and moves to `ST_DONE` once bit 0 is decided. `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `sarc_top`

## Requirements
- R1: `done_o` is high in the cycle that begins 13 rising edges after the edge that sampled `start_i` in idle: one sign cycle followed by exactly 12 bit cycles.
- R2: In the cycle after start is accepted, `sign_chk_o` is 1 and `trial_o` is 0. In the next cycle `trial_o` is 12'h800, with only bit 11 set.
- R3: In each bit cycle, `cmp_i`=1 keeps the bit under trial and `cmp_i`=0 clears it. The next lower bit is then set for the following cycle, from bit 11 down to bit 0.
- R4: With `single_i`=1 the result is the straight binary search code, whatever the value of `bipolar_i`.
- R5: With `single_i`=0 and `bipolar_i`=0 the result is the straight binary code. If `cmp_i` was 0 during the sign cycle, the result is 12'h000.
- R6: With `single_i`=0 and `bipolar_i`=1 the result is the search code with bit 11 inverted, which is two's complement of an input of plus or minus half the reference. The sign sample has no effect.
- R7: A `start_i` pulse during the sign, bit or done cycles is ignored: the running conversion keeps its timing and its result.
- R8: `done_o` lasts one cycle, and `result_o` keeps its value until the next `done_o`.
- R9: `single_i` and `bipolar_i` are captured when start is accepted. Changing them during a conversion does not affect its result.
- R10: After reset, `done_o`, `sign_chk_o`, `trial_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only in idle |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| bipolar_i | input | 1 | 1 = bipolar coding in differential mode |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above trial level (or non-negative in sign cycle) |
| trial_o | output | 12 | Trial code to the DAC, zero outside bit cycles |
| sign_chk_o | output | 1 | High during the sign sample cycle |
| result_o | output | 12 | Coded conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong state or bit index shows up at once on `trial_o`: a sequence that skips or repeats a bit produces a trial code that departs from the expected binary search in the next cycle, and `done_o` then arrives one cycle early or late. Errors in the captured mode or in the sign flag do not show until the `done_o` cycle, as a wrong coding of `result_o`. That is why the bench checks every result against a code computed from the target and the mode, and tests the edge of each range: zero, full scale, the most negative bipolar value and small negative unipolar inputs.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SIGN,
        ST_CONV,
        ST_DONE
    } sarc_state_e;

endpackage

// File: rtl/sarc_fsm.sv
module sarc_fsm
    import sarc_pkg::*;
#(
    parameter int W = 12,
    localparam int IW = $clog2(W)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic          accept_o,
    output logic          sign_o,
    output logic          conv_o,
    output logic          last_o,
    output logic          done_o,
    output logic [IW-1:0] idx_o
);

    localparam logic [IW-1:0] IDX_TOP = IW'(W - 1);

    sarc_state_e   state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_SIGN;
            end
            ST_SIGN: begin
                state_d = ST_CONV;
                idx_d   = IDX_TOP;
            end
            ST_CONV: begin
                if (idx_q == '0) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx_q - 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        sign_o   = 1'b0;
        conv_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start_i;
            ST_SIGN: sign_o   = 1'b1;
            ST_CONV: conv_o   = 1'b1;
            ST_DONE: done_o   = 1'b1;
            default: ;
        endcase
        last_o = conv_o && (idx_q == '0);
        idx_o  = idx_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8
    AST_LAST_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> done_o); // R1
    AST_SIGN_THEN_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sign_o |=> (conv_o && idx_o == IDX_TOP)); // R2
    AST_SEARCH_UNBROKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_o && !last_o) |=> (conv_o && idx_o == $past(idx_o) - 1'b1)); // R7

endmodule

// File: rtl/sarc_shreg.sv
module sarc_shreg #(
    parameter int W = 12,
    localparam int IW = $clog2(W)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sign_i,
    input  logic          conv_i,
    input  logic          cmp_i,
    input  logic [IW-1:0] idx_i,
    output logic [W-1:0]  trial_o,
    output logic [W-1:0]  decided_o
);

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] MSB = ONE << (W - 1);

    logic [W-1:0] trial_q;
    logic [W-1:0] bit_now;
    logic [W-1:0] bit_next;

    always_comb begin
        bit_now   = ONE << idx_i;
        bit_next  = (idx_i == '0) ? '0 : (bit_now >> 1);
        decided_o = cmp_i ? trial_q : (trial_q & ~bit_now);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trial_q <= '0;
        end else if (sign_i) begin
            trial_q <= MSB;
        end else if (conv_i) begin
            trial_q <= decided_o | bit_next;
        end
    end

    assign trial_o = trial_q;

    AST_KEEP_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_i && cmp_i && idx_i != '0) |=> (trial_q > $past(trial_q))); // R3
    AST_DROP_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_i && !cmp_i) |=> (trial_q < $past(trial_q))); // R3

endmodule

// File: rtl/sarc_coder.sv
module sarc_coder #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         accept_i,
    input  logic         single_i,
    input  logic         bipolar_i,
    input  logic         sign_i,
    input  logic         cmp_i,
    input  logic         load_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] result_o
);

    logic         m_single_q;
    logic         m_bip_q;
    logic         neg_q;
    logic [W-1:0] coded;
    logic [W-1:0] result_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_single_q <= 1'b0;
            m_bip_q    <= 1'b0;
        end else if (accept_i) begin
            m_single_q <= single_i;
            m_bip_q    <= bipolar_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            neg_q <= 1'b0;
        end else if (sign_i) begin
            neg_q <= !cmp_i;
        end
    end

    always_comb begin
        if (m_single_q) begin
            coded = code_i;
        end else if (m_bip_q) begin
            coded = {~code_i[W-1], code_i[W-2:0]};
        end else begin
            coded = neg_q ? '0 : code_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_q <= '0;
        end else if (load_i) begin
            result_q <= coded;
        end
    end

    assign result_o = result_q;

    AST_SINGLE_STRAIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && m_single_q) |=> (result_o == $past(code_i))); // R4
    AST_CLAMP_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !m_single_q && !m_bip_q && neg_q) |=> (result_o == '0)); // R5
    AST_BIP_MSB_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !m_single_q && m_bip_q) |=> (result_o[W-1] != $past(code_i[W-1]))); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(result_o)); // R8

endmodule

// File: rtl/sarc_top.sv
module sarc_top #(
    parameter int W = 12,
    localparam int IW = $clog2(W)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         single_i,
    input  logic         bipolar_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic         sign_chk_o,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    logic          accept;
    logic          sign_ph;
    logic          conv_ph;
    logic          last_bit;
    logic [IW-1:0] idx;
    logic [W-1:0]  trial_q;
    logic [W-1:0]  decided;

    sarc_fsm #(.W(W)) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .accept_o (accept),
        .sign_o   (sign_ph),
        .conv_o   (conv_ph),
        .last_o   (last_bit),
        .done_o   (done_o),
        .idx_o    (idx)
    );

    sarc_shreg #(.W(W)) u_shreg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sign_i    (sign_ph),
        .conv_i    (conv_ph),
        .cmp_i     (cmp_i),
        .idx_i     (idx),
        .trial_o   (trial_q),
        .decided_o (decided)
    );

    sarc_coder #(.W(W)) u_coder (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .accept_i  (accept),
        .single_i  (single_i),
        .bipolar_i (bipolar_i),
        .sign_i    (sign_ph),
        .cmp_i     (cmp_i),
        .load_i    (last_bit),
        .code_i    (decided),
        .result_o  (result_o)
    );

    assign trial_o    = conv_ph ? trial_q : '0;
    assign sign_chk_o = sign_ph;

    AST_SIGN_ZERO_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sign_chk_o |-> (trial_o == '0 && !done_o)); // R2
    AST_DONE_NEEDS_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> ($past(trial_o) != '0 || $past(cmp_i) == 1'b0)); // R1

endmodule

// File: tb/sarc_top_bench.sv
module sarc_top_bench;

    localparam int W      = 12;
    localparam int FS     = 1 << W;
    localparam int HALF   = FS / 2;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         single_i = 1'b0;
    logic         bipolar_i = 1'b0;
    logic         cmp_i;
    logic [W-1:0] trial_o;
    logic         sign_chk_o;
    logic [W-1:0] result_o;
    logic         done_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  m_s = 1'b1;
    bit  m_b = 1'b0;
    int  m_t = 0;
    bit  finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sarc_top #(.W(W)) u_sarc_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start_i),
        .single_i   (single_i),
        .bipolar_i  (bipolar_i),
        .cmp_i      (cmp_i),
        .trial_o    (trial_o),
        .sign_chk_o (sign_chk_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    // behavioural front end
    always_comb begin
        if (sign_chk_o)      cmp_i = (m_t >= 0);
        else if (m_s)        cmp_i = (m_t >= int'(trial_o));
        else if (m_b)        cmp_i = ((m_t + HALF) >= int'(trial_o));
        else                 cmp_i = (((m_t < 0) ? -m_t : m_t) >= int'(trial_o));
    end

    function automatic int expect_code(bit s, bit b, int t);
        if (s)      return t;
        if (!b)     return (t < 0) ? 0 : t;
        return t & (FS - 1);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic convert(bit s, bit b, int t, string tag, bit poke, bit flip, bit watch);
        int exp_v;
        int held;
        m_s = s; m_b = b; m_t = t;
        exp_v = expect_code(s, b, t);
        @(negedge clk);
        single_i = s; bipolar_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (watch) begin
            chk(sign_chk_o == 1'b1, "R2 sign cycle flag", int'(sign_chk_o), 1);
            chk(trial_o == '0, "R2 sign cycle trial", int'(trial_o), 0);
        end
        for (int k = 1; k <= 13; k++) begin
            if (poke && k == 5) start_i = 1'b1;
            if (flip && k == 3) begin
                single_i = ~s; bipolar_i = ~b;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (watch && k == 1)
                chk(trial_o == 12'h800, "R2 first trial", int'(trial_o), 'h800);
            if (k == 12)
                chk(done_o == 1'b0, "R1 done not early", int'(done_o), 0);
        end
        chk(done_o == 1'b1, "R1 done at cycle 13", int'(done_o), 1);
        chk(int'(result_o) == exp_v, tag, int'(result_o), exp_v);
        held = int'(result_o);
        single_i = s; bipolar_i = b;
        repeat (2) @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
        chk(int'(result_o) == held, "R8 result held", int'(result_o), held);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R10 reset done", int'(done_o), 0);
        chk(sign_chk_o == 1'b0, "R10 reset sign", int'(sign_chk_o), 0);
        chk(trial_o == '0, "R10 reset trial", int'(trial_o), 0);
        chk(result_o == '0, "R10 reset result", int'(result_o), 0);
        rst_n = 1'b1;

        // directed corners
        convert(1, 0, 12'hABC, "R3 search pattern", 0, 0, 1);
        convert(1, 0, 0,       "R4 single zero", 0, 0, 0);
        convert(1, 0, FS - 1,  "R4 single full scale", 0, 0, 0);
        convert(1, 1, 1234,    "R4 single ignores bipolar", 0, 0, 0);
        convert(0, 0, 3000,    "R5 unipolar positive", 0, 0, 0);
        convert(0, 0, -1,      "R5 unipolar clamp small", 0, 0, 0);
        convert(0, 0, -2500,   "R5 unipolar clamp large", 0, 0, 0);
        convert(0, 1, -HALF,   "R6 bipolar most negative", 0, 0, 0);
        convert(0, 1, HALF - 1, "R6 bipolar most positive", 0, 0, 0);
        convert(0, 1, -5,      "R6 bipolar negative", 0, 0, 0);
        convert(0, 1, 0,       "R6 bipolar zero", 0, 0, 0);
        convert(0, 1, 777,     "R7 start ignored busy", 1, 0, 0);
        convert(0, 0, -300,    "R9 mode latched", 0, 1, 0);
        convert(1, 0, 2049,    "R9 single latched", 0, 1, 0);

        // random mix
        for (int i = 0; i < 60; i++) begin
            int mode = int'($urandom % 3);
            int t;
            if (mode == 0) begin
                t = int'($urandom % FS);
                convert(1, 1'($urandom % 2), t, "R4 random single", 0, 0, 0);
            end else if (mode == 1) begin
                t = int'($urandom % (2 * FS - 1)) - (FS - 1);
                convert(0, 0, t, "R5 random unipolar", 0, 0, 0);
            end else begin
                t = int'($urandom % FS) - HALF;
                convert(0, 1, t, "R6 random bipolar", 0, 0, 0);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule